// File: doc/BRIEF.md
# Retriggerable Dual-Edge One-Shot Pulse Generator

This block is a clocked model of a single retriggerable monostable channel. A pulse of programmable length, counted in clock cycles, is started by one of three qualified edges. The first is a falling edge on the fall-trigger input. The second is a rising edge on the rise-trigger input. The third is a rising edge on the active-low clear input. Each edge is accepted only when the other two inputs sit at their enabling levels. While the clear input is low, the pulse is held off.

All three control inputs are asynchronous. Each passes through a two-flop synchroniser, and edges are found by comparing the second stage with a third history flop. The duration input is sampled on the cycle a trigger is accepted. A trigger that arrives during a pulse reloads the full count, which stretches the pulse. The design provides a true output and a complementary output.

Top module: `oneshot_retrig`

## Requirements
- R1: While the synchronous reset `rst` is high, and directly after it, `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: A falling edge on `trig_fall_i` while `trig_rise_i` is 1 and `clr_n_i` is 1 starts a pulse. Take an input change made between clock edges: `pulse_o` is first high after the third following rising clock edge. It then stays high for exactly `dur_i` cycles.
- R3: A rising edge on `trig_rise_i` while `trig_fall_i` is 0 and `clr_n_i` is 1 starts a pulse, with the same latency and length as in R2.
- R4: A rising edge on `clr_n_i` while `trig_fall_i` is 0 and `trig_rise_i` is 1 starts a pulse, with the same latency and length as in R2.
- R5: Some input changes must leave the output unchanged. These are: a falling edge on `trig_fall_i` with `trig_rise_i` low, a rising edge on `trig_rise_i` with `trig_fall_i` high, a rising `clr_n_i` with `trig_fall_i` high or `trig_rise_i` low, and any falling edge on `trig_rise_i`.
- R6: `clr_n_i` low forces `pulse_o` low no later than the third rising clock edge after the change. This also ends a pulse in progress. No trigger is accepted while the clear input is low.
- R7: A trigger edge and a falling `clr_n_i` can reach the block in the same cycle. In that case the clear wins and no pulse is produced.
- R8: A qualified trigger during a pulse reloads the count. The pulse then ends `dur_i` cycles after the latest trigger takes effect. This holds even when the reload falls on the final cycle of the pulse.
- R9: A `dur_i` of 0 gives a pulse of exactly one cycle.
- R10: `pulse_n_o` is always the complement of `pulse_o`.
- R11: Levels present on the inputs during reset do not count as edges. Holding the armed levels (fall input 0, rise input 1, clear 1) across reset release produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_fall_i | input | 1 | Asynchronous trigger, active on its falling edge |
| trig_rise_i | input | 1 | Asynchronous trigger, active on its rising edge |
| clr_n_i | input | 1 | Asynchronous clear, active low; its rising edge can also trigger |
| dur_i | input | CNT_W | Pulse length in clock cycles (0 behaves as 1) |
| pulse_o | output | 1 | Pulse output |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a trigger and the clear. The bench drops the clear input at the same moment as a qualifying fall-trigger edge, so both changes travel through the synchronisers together. The result is judged by watching that no pulse cycle appears. The second pair is a retrigger and the natural end of a pulse. Here a second rising edge is timed so that its reload reaches the counter on the last cycle of a three-cycle pulse. The expected result is one unbroken run of six high cycles, with no gap.

// File: rtl/oneshot_retrig.sv
module oneshot_retrig #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_fall_i,
  input  logic             trig_rise_i,
  input  logic             clr_n_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  // per input: [0] first sync stage, [1] second stage, [2] history
  logic [2:0]       fall_sh, rise_sh, clr_sh;
  logic [1:0]       warm;
  logic [CNT_W-1:0] cnt;

  logic a_lvl, b_lvl, c_lvl;
  logic a_fell, b_rose, c_rose;
  logic edge_en, trig;
  logic [CNT_W-1:0] load_val;

  assign a_lvl  = fall_sh[1];
  assign b_lvl  = rise_sh[1];
  assign c_lvl  = clr_sh[1];
  assign a_fell = fall_sh[2] & ~fall_sh[1];
  assign b_rose = ~rise_sh[2] & rise_sh[1];
  assign c_rose = ~clr_sh[2] & clr_sh[1];

  assign edge_en = (warm == 2'd3);
  assign trig = edge_en & c_lvl &
                ((a_fell & b_lvl) | (b_rose & ~a_lvl) | (c_rose & ~a_lvl & b_lvl));

  assign load_val = (dur_i == '0) ? CNT_W'(1) : dur_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_sh <= '0;
      rise_sh <= '0;
      clr_sh  <= '0;
      warm    <= '0;
    end else begin
      fall_sh <= {fall_sh[1:0], trig_fall_i};
      rise_sh <= {rise_sh[1:0], trig_rise_i};
      clr_sh  <= {clr_sh[1:0], clr_n_i};
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (!c_lvl)      cnt <= '0;
    else if (trig)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign pulse_o   = (cnt != '0);
  assign pulse_n_o = ~pulse_o;

endmodule

// File: rtl/oneshot_retrig_chk.sv
module oneshot_retrig_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pulse_o,
  input logic             pulse_n_o,
  input logic             clr_lvl,
  input logic             trig,
  input logic             edge_en,
  input logic [CNT_W-1:0] cnt
);

  p_out_complement_r10: assert property (@(posedge clk) disable iff (rst)
    pulse_n_o == !pulse_o);

  p_clear_forces_low_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_lvl |=> !pulse_o);

  p_trig_raises_r8: assert property (@(posedge clk) disable iff (rst)
    trig |=> pulse_o);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    (!pulse_o && !trig) |=> !pulse_o);

  p_warmup_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !edge_en |=> !pulse_o);

  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !trig && clr_lvl) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

bind oneshot_retrig oneshot_retrig_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pulse_o  (pulse_o),
  .pulse_n_o(pulse_n_o),
  .clr_lvl  (clr_sh[1]),
  .trig     (trig),
  .edge_en  (edge_en),
  .cnt      (cnt)
);

// File: tb/oneshot_retrig_test.sv
module oneshot_retrig_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int NVEC = 12;

  // {start a,b,c, end a,b,c, dur[7:0], expected length[7:0], req[7:0]}
  localparam logic [29:0] VECS [NVEC] = '{
    {3'b111, 3'b011, 8'd5, 8'd5, 8'd2},  // R2 fall edge, rise high
    {3'b001, 3'b011, 8'd4, 8'd4, 8'd3},  // R3 rise edge, fall low
    {3'b010, 3'b011, 8'd6, 8'd6, 8'd4},  // R4 clear rising, armed levels
    {3'b101, 3'b001, 8'd4, 8'd0, 8'd5},  // R5 fall edge with rise low
    {3'b101, 3'b111, 8'd4, 8'd0, 8'd5},  // R5 rise edge with fall high
    {3'b110, 3'b111, 8'd3, 8'd0, 8'd5},  // R5 clear rising with fall high
    {3'b000, 3'b001, 8'd3, 8'd0, 8'd5},  // R5 clear rising with rise low
    {3'b011, 3'b001, 8'd3, 8'd0, 8'd5},  // R5 falling rise input
    {3'b110, 3'b010, 8'd3, 8'd0, 8'd6},  // R6 fall edge while clear low
    {3'b111, 3'b010, 8'd3, 8'd0, 8'd7},  // R7 fall edge and clear drop together
    {3'b111, 3'b011, 8'd0, 8'd1, 8'd9},  // R9 zero duration
    {3'b001, 3'b011, 8'd1, 8'd1, 8'd3}   // R3 one-cycle pulse
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b0, b = 1'b1, c = 1'b1;
  logic [CNT_W-1:0] dur = CNT_W'(4);
  logic q, qn;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_retrig #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .trig_fall_i(a), .trig_rise_i(b), .clr_n_i(c),
    .dur_i(dur), .pulse_o(q), .pulse_n_o(qn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // samples n negedges after a change; reports first high index, high count, complement
  task automatic watch(input int n, output int first, output int cnt_hi,
                       output int last, output bit comp_ok);
    first = 0; cnt_hi = 0; last = 0; comp_ok = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (qn !== ~q) comp_ok = 1'b0;
      if (q === 1'b1) begin
        if (first == 0) first = i;
        last = i;
        cnt_hi++;
      end
    end
  endtask

  task automatic settle(input logic a0, input logic b0, input logic c0);
    dur = CNT_W'(1);
    c = 1'b0;
    repeat (5) @(negedge clk);
    a = a0; b = b0;
    repeat (5) @(negedge clk);
    c = c0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int first, hi, last;
    bit comp;
    // R1: outputs during reset
    repeat (4) @(negedge clk);
    chk(q === 1'b0, "R1", q, 0);
    chk(qn === 1'b1, "R1", qn, 1);
    rst = 1'b0;
    // R11: armed levels held across reset release give no pulse
    watch(12, first, hi, last, comp);
    chk(hi == 0, "R11", hi, 0);
    chk(comp, "R10", 0, 1);

    for (int v = 0; v < NVEC; v++) begin
      logic [29:0] e;
      string tag;
      e = VECS[v];
      tag = $sformatf("R%0d", e[7:0]);
      settle(e[29], e[28], e[27]);
      dur = CNT_W'(e[23:16]);
      @(negedge clk);
      {a, b, c} = e[26:24];
      watch(30, first, hi, last, comp);
      chk(hi == int'(e[15:8]), tag, hi, int'(e[15:8]));
      if (e[15:8] != 0) begin
        chk(first == 3, tag, first, 3);
        chk(last - first + 1 == hi, tag, last - first + 1, hi);
      end
      chk(comp, "R10", 0, 1);
    end

    // R8: retrigger mid-pulse extends to full duration after latest trigger
    settle(1'b0, 1'b0, 1'b1);
    dur = CNT_W'(6);
    @(negedge clk);
    b = 1'b1;
    @(negedge clk); @(negedge clk);
    b = 1'b0;
    @(negedge clk); @(negedge clk);
    b = 1'b1;
    watch(20, first, hi, last, comp);
    // first trigger took effect at index 3; second at index 3 relative to its change
    // relative to this window: high indices 1..8 (pulse from first continues), ends after 8
    chk(hi == 8, "R8", hi, 8);
    chk(first == 1 && last == 8, "R8", last, 8);

    // R8: reload on the last cycle of a three-cycle pulse keeps the pulse unbroken
    settle(1'b0, 1'b0, 1'b1);
    dur = CNT_W'(3);
    @(negedge clk);
    b = 1'b1;
    @(negedge clk);
    b = 1'b0;
    @(negedge clk); @(negedge clk);
    b = 1'b1;
    watch(12, first, hi, last, comp);
    // window starts 3 negedges after first change: highs at 1..5 of this window
    chk(hi == 5, "R8", hi, 5);
    chk(first == 1 && last - first + 1 == hi, "R8", last - first + 1, hi);

    // R6: clear ends a long pulse in progress
    settle(1'b0, 1'b0, 1'b1);
    dur = CNT_W'(20);
    @(negedge clk);
    b = 1'b1;
    repeat (5) @(negedge clk);
    chk(q === 1'b1, "R6", q, 1);
    c = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(q === 1'b1, "R6", q, 1);
    @(negedge clk);
    chk(q === 1'b0, "R6", q, 0);
    watch(10, first, hi, last, comp);
    chk(hi == 0, "R6", hi, 0);
    b = 1'b0;
    repeat (5) @(negedge clk);
    c = 1'b1;
    watch(10, first, hi, last, comp);
    chk(hi == 0, "R5", hi, 0);

    // R1: reset mid-pulse clears outputs
    dur = CNT_W'(20);
    b = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(q === 1'b0 && qn === 1'b1, "R1", q, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule